// File: doc/BRIEF.md
# Drive Indicator Serial Stream Transmitter

The block holds the indicator state of up to eight disk ports: three lamps per port, for fault, locate and activity. A controller hands it one update at a time, each made of a port number and a 32-bit message word. The block pulls the three lamp states out of the word. It then finds the port's position in the outgoing bit stream through a writable remap table, and rewrites that port's three pattern bits.

Each accepted update starts a full frame on three wires: a serial clock, a load strobe and a data line. The frame opens with one clock pulse while load is high. The whole pattern then follows, least significant bit first, three bits for each configured port. A half-period counter in system clock cycles sets the pulse timing.

A small configuration write port sets the number of active ports and the table entries. Updates come in through a valid/ready handshake, which holds new requests off while a frame is on the wire.

Top module: `led_stream_tx`

## Requirements
- R1: After reset, sgp_clk, sgp_load and sgp_data are all high, busy and req_err are low, and req_ready is high.
- R2: For a port at stream slot s, pattern bit 3s holds message bit 22 (fault), bit 3s+1 holds message bit 19 (locate), and bit 3s+2 holds message bit 20 OR bit 21 (activity); all three are rewritten on every accepted update, so a zero clears them.
- R3: The remap table resets to port 0 → slot 4, ports 1..4 → slots 0..3, ports 5..7 → themselves; a write with cfg_is_count=0 stores cfg_val[2:0] as the slot of port cfg_idx.
- R4: An accepted request with message bits [15:8] ≥ 15, or with req_port ≥ the port count, raises req_err for exactly the cycle after acceptance, leaves the pattern unchanged and sends no frame.
- R5: A frame opens in the cycle after acceptance with sgp_load and sgp_clk high. One clock pulse follows with load high, and load falls while the clock is low, before the first data pulse.
- R6: After the load pulse the frame carries exactly 3×N data pulses (N = port count), pattern bit 0 first; sgp_data changes only while sgp_clk is low and holds its value through each high phase.
- R7: Every clock pulse in a frame is high for HALF_CYC cycles and then low for HALF_CYC cycles.
- R8: busy rises in the cycle after acceptance and stays high for 2×HALF_CYC×(1+3N) cycles; req_ready is the inverse of busy, so a request presented while busy waits and is taken once busy falls.
- R9: Between frames sgp_clk and sgp_load stay low and sgp_data keeps the last bit sent.
- R10: A write with cfg_is_count=1 sets the port count to cfg_val when cfg_val ≤ 8 and is ignored otherwise; the count resets to 5.
- R11: When a configuration write and a request acceptance fall in the same cycle, the request uses the count and table as they were before that write; the write applies to later requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_count | input | 1 | 1: write port count, 0: write remap entry |
| cfg_idx | input | 3 | Port whose remap entry is written |
| cfg_val | input | 4 | Port count, or slot in bits [2:0] |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block can take a request |
| req_port | input | 4 | Port the update belongs to |
| req_msg | input | 32 | Message word carrying lamp states and slot field |
| req_err | output | 1 | One-cycle pulse: last accepted request was rejected |
| busy | output | 1 | A frame is being sent |
| sgp_clk | output | 1 | Serial clock to the lamp controller |
| sgp_load | output | 1 | Frame start strobe |
| sgp_data | output | 1 | Serial pattern data |

## Verification
A configuration write and a request acceptance can fall in the same clock edge. The bench provokes this by driving a port-count write on the very cycle a request is accepted. The request's port is valid under the old count but invalid under the new one. The frame that follows must carry 3×(old count) bits with no error, and the next request for that port must be rejected. The bench also queues a request while a frame is still running, to show it waits rather than colliding with the frame in progress.

// File: rtl/led_stream_pkg.sv
package led_stream_pkg;
  localparam int BITS_PER_PORT = 3;
  localparam int OFS_FAULT     = 0;
  localparam int OFS_LOCATE    = 1;
  localparam int OFS_ACTIVE    = 2;
  localparam int MSG_FAULT     = 22;
  localparam int MSG_LOCATE    = 19;
  localparam int MSG_ACT_A     = 20;
  localparam int MSG_ACT_B     = 21;
  localparam int MSG_SLOT_LSB  = 8;
  localparam int MSG_SLOT_W    = 8;

  function automatic int reset_slot(input int port, input int first_slot);
    if (port == 0)                return first_slot;
    else if (port <= first_slot)  return port - 1;
    else                          return port;
  endfunction
endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_stream_pkg::*;
#(
  parameter int MAX_PORTS  = 8,
  parameter int DEF_PORTS  = 5,
  parameter int FIRST_SLOT = 4,
  localparam int PW = $clog2(MAX_PORTS),
  localparam int CW = $clog2(MAX_PORTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic                  cfg_is_count,
  input  logic [PW-1:0]         cfg_idx,
  input  logic [CW-1:0]         cfg_val,
  output logic [CW-1:0]         port_count,
  output logic [MAX_PORTS*PW-1:0] map_flat
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PORTS);

  always_ff @(posedge clk) begin
    if (rst)
      port_count <= CW'(DEF_PORTS);
    else if (cfg_we && cfg_is_count && (cfg_val <= CNT_MAX))
      port_count <= cfg_val;
  end

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_map
    always_ff @(posedge clk) begin
      if (rst)
        map_flat[p*PW +: PW] <= PW'(reset_slot(p, FIRST_SLOT));
      else if (cfg_we && !cfg_is_count && (cfg_idx == PW'(p)))
        map_flat[p*PW +: PW] <= cfg_val[PW-1:0];
    end
  end

  AST_COUNT_OVER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_is_count && (cfg_val > CNT_MAX)) |=> $stable(port_count)); // R10
endmodule

// File: rtl/led_pattern_upd.sv
module led_pattern_upd
  import led_stream_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int MSG_SLOTS = 15,
  localparam int PW    = $clog2(MAX_PORTS),
  localparam int CW    = $clog2(MAX_PORTS + 1),
  localparam int PAT_W = BITS_PER_PORT * MAX_PORTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic [CW-1:0]           req_port,
  input  logic [31:0]             req_msg,
  input  logic [CW-1:0]           port_count,
  input  logic [MAX_PORTS*PW-1:0] map_flat,
  output logic                    start,
  output logic [PAT_W-1:0]        pat_new,
  output logic                    err_q,
  output logic [PAT_W-1:0]        pattern_q
);
  localparam logic [MSG_SLOT_W-1:0] SLOT_LIM = MSG_SLOT_W'(MSG_SLOTS);

  logic [PW-1:0]         slot;
  logic [MSG_SLOT_W-1:0] msg_slot;
  logic                  bad;
  logic                  unused_msg_bits;

  assign msg_slot        = req_msg[MSG_SLOT_LSB +: MSG_SLOT_W];
  assign slot            = map_flat[req_port[PW-1:0]*PW +: PW];
  assign bad             = (req_port >= port_count) || (msg_slot >= SLOT_LIM);
  assign start           = accept && !bad;
  assign unused_msg_bits = ^{req_msg[31:23], req_msg[18:16], req_msg[7:0]};

  always_comb begin
    int base;
    base    = BITS_PER_PORT * int'(slot);
    pat_new = pattern_q;
    pat_new[base + OFS_FAULT]  = req_msg[MSG_FAULT];
    pat_new[base + OFS_LOCATE] = req_msg[MSG_LOCATE];
    pat_new[base + OFS_ACTIVE] = req_msg[MSG_ACT_A] | req_msg[MSG_ACT_B];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pattern_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= accept && bad;
      if (start) pattern_q <= pat_new;
    end
  end

  AST_REJECT_KEEPS_PATTERN: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (pattern_q == $past(pattern_q))); // R4
endmodule

// File: rtl/led_frame_shifter.sv
module led_frame_shifter
  import led_stream_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int HALF_CYC  = 6250,
  localparam int CW    = $clog2(MAX_PORTS + 1),
  localparam int PAT_W = BITS_PER_PORT * MAX_PORTS,
  localparam int HW    = $clog2(HALF_CYC),
  localparam int PHW   = $clog2(2 * (1 + PAT_W) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAT_W-1:0] pat_new,
  input  logic [CW-1:0]    port_count,
  output logic             sclk,
  output logic             sload,
  output logic             sdata,
  output logic             busy
);
  localparam logic [HW-1:0] HALF_M1 = HW'(HALF_CYC - 1);
  localparam logic [HW-1:0] HALF_M2 = HW'(HALF_CYC - 2);

  logic [HW-1:0]    hc;
  logic [PHW-1:0]   ph;
  logic [PHW-1:0]   last_ph;
  logic [PAT_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= 1'b1;
      sload   <= 1'b1;
      sdata   <= 1'b1;
      busy    <= 1'b0;
      hc      <= '0;
      ph      <= '0;
      last_ph <= '0;
      shreg   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        sclk    <= 1'b1;
        sload   <= 1'b1;
        hc      <= '0;
        ph      <= '0;
        last_ph <= PHW'(2 * BITS_PER_PORT * int'(port_count) + 1);
        shreg   <= pat_new;
      end
    end else begin
      if (hc == HALF_M1) begin
        hc <= '0;
        ph <= ph + 1'b1;
        if (!ph[0])              sclk <= 1'b0;
        else if (ph == last_ph)  busy <= 1'b0;
        else                     sclk <= 1'b1;
      end else begin
        hc <= hc + 1'b1;
      end
      if (ph[0] && (hc == HALF_M2) && (ph != last_ph)) begin
        sload <= 1'b0;
        sdata <= shreg[0];
        shreg <= shreg >> 1;
      end
    end
  end

  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && sload && sclk)); // R5
  AST_LOAD_DROP_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(sload) |-> (!sclk && busy)); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(sdata)) |-> !sclk); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(sdata) && $stable(sload) && $stable(sclk))); // R9
endmodule

// File: rtl/led_stream_tx.sv
module led_stream_tx
  import led_stream_pkg::*;
#(
  parameter int MAX_PORTS  = 8,
  parameter int DEF_PORTS  = 5,
  parameter int FIRST_SLOT = 4,
  parameter int MSG_SLOTS  = 15,
  parameter int HALF_CYC   = 6250
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic                              cfg_is_count,
  input  logic [$clog2(MAX_PORTS)-1:0]      cfg_idx,
  input  logic [$clog2(MAX_PORTS+1)-1:0]    cfg_val,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [$clog2(MAX_PORTS+1)-1:0]    req_port,
  input  logic [31:0]                       req_msg,
  output logic                              req_err,
  output logic                              busy,
  output logic                              sgp_clk,
  output logic                              sgp_load,
  output logic                              sgp_data
);
  localparam int PW    = $clog2(MAX_PORTS);
  localparam int CW    = $clog2(MAX_PORTS + 1);
  localparam int PAT_W = BITS_PER_PORT * MAX_PORTS;

  logic [CW-1:0]           port_count;
  logic [MAX_PORTS*PW-1:0] map_flat;
  logic                    accept;
  logic                    start;
  logic [PAT_W-1:0]        pat_new;
  logic [PAT_W-1:0]        pattern_q;
  logic                    unused_pattern;

  assign req_ready      = !busy;
  assign accept         = req_valid && req_ready;
  assign unused_pattern = ^pattern_q;

  led_cfg_regs #(.MAX_PORTS(MAX_PORTS), .DEF_PORTS(DEF_PORTS), .FIRST_SLOT(FIRST_SLOT)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_count(cfg_is_count),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val), .port_count(port_count), .map_flat(map_flat)
  );

  led_pattern_upd #(.MAX_PORTS(MAX_PORTS), .MSG_SLOTS(MSG_SLOTS)) u_pat (
    .clk(clk), .rst(rst), .accept(accept), .req_port(req_port), .req_msg(req_msg),
    .port_count(port_count), .map_flat(map_flat), .start(start), .pat_new(pat_new),
    .err_q(req_err), .pattern_q(pattern_q)
  );

  led_frame_shifter #(.MAX_PORTS(MAX_PORTS), .HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst(rst), .start(start), .pat_new(pat_new), .port_count(port_count),
    .sclk(sgp_clk), .sload(sgp_load), .sdata(sgp_data), .busy(busy)
  );

  AST_BUSY_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)); // R8
  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_err |-> !busy); // R4
endmodule

// File: tb/led_stream_tx_test.sv
module led_stream_tx_test;
  localparam int MAXP = 8;
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_we, cfg_is_count, req_valid;
  logic [2:0] cfg_idx;
  logic [3:0] cfg_val, req_port;
  logic [31:0] req_msg;
  logic req_ready, req_err, busy, sgp_clk, sgp_load, sgp_data;

  led_stream_tx #(.MAX_PORTS(MAXP), .HALF_CYC(HALF)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_count(cfg_is_count),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_msg(req_msg), .req_err(req_err), .busy(busy),
    .sgp_clk(sgp_clk), .sgp_load(sgp_load), .sgp_data(sgp_data)
  );

  typedef struct { logic [23:0] bits; int n; } frame_t;
  frame_t exp_q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] m_pat = '0;
  int m_map[8] = '{4, 0, 1, 2, 3, 5, 6, 7};
  int m_cnt = 5;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: models the request, queues the expected frame, then drives it
  task automatic send(input int port, input logic [31:0] msg, input bit early,
                      input bit with_cfg, input int cnt_val, input string tag);
    bit bad;
    int slot;
    frame_t f;
    @(negedge clk);
    if (!early) while (!req_ready) @(negedge clk);
    bad = (port >= m_cnt) || (msg[15:8] >= 8'd15);
    if (!bad) begin
      slot = m_map[port];
      m_pat[3*slot]     = msg[22];
      m_pat[3*slot + 1] = msg[19];
      m_pat[3*slot + 2] = msg[20] | msg[21];
      f.n    = 3 * m_cnt;
      f.bits = m_pat & ((24'h1 << f.n) - 24'h1);
      if (f.n == 24) f.bits = m_pat;
      exp_q.push_back(f);
    end
    req_valid = 1'b1;
    req_port  = 4'(port);
    req_msg   = msg;
    if (with_cfg) begin
      cfg_we = 1'b1; cfg_is_count = 1'b1; cfg_val = 4'(cnt_val);
    end
    if (early) begin
      chk(req_ready == 1'b0, "R8", "request offered during frame sees ready low", int'(req_ready), 0);
      while (!req_ready) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b0;
    chk(req_err == bad, tag, "error pulse after acceptance", int'(req_err), int'(bad));
    chk(busy == !bad, tag, "busy after acceptance", int'(busy), int'(!bad));
    if (!bad) chk(req_ready == 1'b0, "R8", "ready low while busy", int'(req_ready), 0);
    @(negedge clk);
    chk(req_err == 1'b0, "R4", "error pulse lasts one cycle", int'(req_err), 0);
    if (with_cfg && cnt_val <= 8) m_cnt = cnt_val;
  endtask

  task automatic cfg_write(input bit is_count, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_count = is_count; cfg_idx = 3'(idx); cfg_val = 4'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_count) begin
      if (val <= 8) m_cnt = val;
    end else begin
      m_map[idx] = val & 7;
    end
  endtask

  // monitor: rebuilds each frame from the wires and compares with the queue
  bit mon_busy = 0, mon_sclk = 0, tbad = 0, dbad = 0, lbad = 0, rise_d = 0;
  int hi = 0, lo = 0, nb = 0, bcyc = 0;
  logic [23:0] got = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !mon_busy) begin
        hi = 1; lo = 0; nb = 0; bcyc = 1; got = '0;
        tbad = 0; dbad = 0; lbad = 0;
        mon_sclk = sgp_clk;
        chk(sgp_load && sgp_clk, "R5", "frame opens with load and clock high",
            int'({sgp_load, sgp_clk}), 3);
      end else if (busy) begin
        bcyc++;
        if (sgp_clk && !mon_sclk) begin
          if (lo != HALF) tbad = 1;
          if (sgp_load) lbad = 1;
          if (nb < 24) got[nb] = sgp_data;
          rise_d = sgp_data;
          nb++;
          hi = 1; lo = 0;
        end else if (!sgp_clk && mon_sclk) begin
          if (hi != HALF) tbad = 1;
          if (nb > 0 && sgp_data != rise_d) dbad = 1;
          lo = 1; hi = 0;
        end else if (sgp_clk) hi++;
        else lo++;
        mon_sclk = sgp_clk;
      end else if (!busy && mon_busy) begin
        frame_t e;
        if (lo != HALF) tbad = 1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "frame without an accepted valid request", nb, 0);
        end else begin
          e = exp_q.pop_front();
          chk(nb == e.n, "R6", "data pulses in frame", nb, e.n);
          chk(got == e.bits, "R2", "pattern bits sent LSB first", int'(got), int'(e.bits));
          chk(!tbad, "R7", "pulse high/low lengths", int'(tbad), 0);
          chk(!dbad, "R6", "data stable through high phase", int'(dbad), 0);
          chk(!lbad, "R5", "load low at every data pulse", int'(lbad), 0);
          chk(bcyc == 2*HALF*(1 + e.n), "R8", "busy length", bcyc, 2*HALF*(1 + e.n));
          chk(!sgp_load && !sgp_clk && (nb == 0 || sgp_data == got[nb-1]), "R9",
              "idle after frame holds last bit", int'({sgp_load, sgp_clk, sgp_data}),
              int'({2'b00, (nb == 0) ? 1'b0 : got[nb-1]}));
        end
      end
      mon_busy = busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_is_count = 0; cfg_idx = 0; cfg_val = 0;
    req_valid = 0; req_port = 0; req_msg = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sgp_clk && sgp_load && sgp_data, "R1", "outputs idle high",
        int'({sgp_clk, sgp_load, sgp_data}), 7);
    chk(!busy && !req_err && req_ready, "R1", "busy/err low, ready high",
        int'({busy, req_err, req_ready}), 1);

    send(0, 32'h0040_0000, 0, 0, 0, "R3");   // fault, port 0 -> slot 4
    send(1, 32'h0008_0000, 0, 0, 0, "R2");   // locate, port 1 -> slot 0
    send(2, 32'h0020_0000, 0, 0, 0, "R2");   // activity via bit 21
    send(3, 32'h0010_0000, 1, 0, 0, "R8");   // activity via bit 20, offered while busy
    send(0, 32'h0000_0000, 0, 0, 0, "R2");   // clears port 0
    send(5, 32'h0070_0000, 0, 0, 0, "R4");   // port beyond count
    send(1, 32'h0040_0F00, 0, 0, 0, "R4");   // slot field 15 rejected
    send(1, 32'h0040_0E00, 0, 0, 0, "R4");   // slot field 14 accepted

    cfg_write(1, 0, 8);                      // R10 count = 8
    cfg_write(0, 5, 6);                      // R3 port 5 -> slot 6
    send(5, 32'h0068_0000, 0, 0, 0, "R3");
    send(7, 32'h0010_0000, 0, 0, 0, "R10");
    cfg_write(1, 0, 9);                      // R10 ignored
    send(7, 32'h0000_0000, 0, 0, 0, "R10");

    send(4, 32'h0008_0000, 0, 1, 2, "R11");  // count write in the same cycle
    send(4, 32'h0008_0000, 0, 0, 0, "R11");  // now rejected
    send(1, 32'h0040_0000, 0, 0, 0, "R11");  // 6-bit frame

    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!sgp_clk && !sgp_load, "R9", "clock and load stay low between frames",
        int'({sgp_clk, sgp_load}), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule